// File: doc/BRIEF.md
# Sticky receive status interrupt register

This block gathers error and condition events from a cell-based receive and transmit datapath and holds them in an 8-bit status word. Software reads that word through a single-strobe register port. Some events arrive as pulses from neighbouring logic: header check error, undefined line symbol and receive FIFO overflow. Others are derived inside the block. A gap counter measures how many receive bytes lie between consecutive start-of-cell markers and flags cells that are too short. An edge detector flags any change in the signal-quality level. A parity checker flags transmit bytes that fail odd parity while checking is enabled.

Each event bit stays set until the register is read. The read returns the current word and clears the latched bits in the same cycle. An event that coincides with the read still lands in the cleared word, so it is never lost. Bit 6 is not latched: it shows the present signal-quality level. A registered interrupt output is high whenever any latched bit is set.

Top module: `rx_status_irq_reg`

## Requirements
- R1: While `rst_i` is high and on the first cycle after it, `rd_data_o` is 0x00, `irq_o` is 0 and every latched bit is 0.
- R2: A read (`rd_i` high for one cycle) updates `rd_data_o` at that clock edge with the following word: bit 7 = 0, bit 6 = live level, bit 5 = header check error, bit 4 = short cell, bit 3 = transmit parity error, bit 2 = signal change, bit 1 = undefined symbol, bit 0 = FIFO overflow. Between reads, `rd_data_o` holds its value.
- R3: An event input that is high in cycle T sets its latched bit at the edge that ends T, so a read issued in cycle T+1 or later returns it.
- R4: A read clears all latched bits. An event present in the same cycle as the read is not in that read's data, and it is still set for the next read. With no read, a latched bit never clears.
- R5: Every valid receive byte counts toward the cell length, and a valid byte marked as start of cell is counted as byte 1. A marker byte sets bit 4 when the bytes counted since the previous marker number fewer than 53. At 53 bytes or more there is no flag, and the count saturates at 53. Cycles without a valid byte do not count.
- R6: The first start-of-cell marker after reset never sets bit 4.
- R7: A change of `sig_good_i` from 0 to 1 or from 1 to 0 sets bit 2. A level held steady through and after reset sets nothing.
- R8: When `tx_par_chk_en_i` is 1 and `tx_byte_vld_i` is 1, bit 3 sets if `tx_data_i` together with `tx_par_i` holds an even number of ones. It never sets while the enable is 0 or the byte is not valid.
- R9: `irq_o` is high exactly when at least one of bits 5..0 is latched. It rises at the same edge as the bit and falls at the edge of a clearing read that sees no concurrent event.
- R10: Bit 6 of a read equals `sig_good_i` in the read cycle (1 = good, 0 = bad).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| hec_err_i | input | 1 | Header check error pulse |
| sym_err_i | input | 1 | Undefined line symbol pulse |
| fifo_ovf_i | input | 1 | Receive FIFO overflow pulse |
| sig_good_i | input | 1 | Signal-quality level, 1 = good |
| rx_byte_vld_i | input | 1 | A receive byte is present this cycle |
| rx_soc_i | input | 1 | The present receive byte starts a cell |
| tx_byte_vld_i | input | 1 | A transmit byte is present this cycle |
| tx_data_i | input | 8 | Transmit data byte |
| tx_par_i | input | 1 | Odd parity bit for the transmit byte |
| tx_par_chk_en_i | input | 1 | Enables transmit parity checking |
| rd_i | input | 1 | Register read strobe |
| rd_data_o | output | 8 | Status word captured by the last read |
| irq_o | output | 1 | Interrupt, high while any latched bit is set |

## Verification
On every cycle, the assertions check the following. A latched bit never drops without a read. A read with no concurrent event leaves the word empty. The read data stays still between reads. The interrupt rises only after an event. The gap count stays at or below the cell length. A parity flag appears only after a checked byte.
The bench scenarios are needed for the rest. They sweep every cell length from 1 to 60 with idle gaps, exempt the first marker, run all 1024 combinations of transmit byte, parity bit and enable, and map every combination of the pulse inputs onto its bit position. They also cover the collision of a read with a new event, and both directions of the level change against the live bit.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int STAT_W    = 8;
  localparam int STICKY_W  = 6;
  // positions fixed because software decodes them
  localparam int B_OVF     = 0;
  localparam int B_SYM     = 1;
  localparam int B_CHG     = 2;
  localparam int B_PAR     = 3;
  localparam int B_SHORT   = 4;
  localparam int B_HEC     = 5;
  localparam int B_LIVE    = 6;

  typedef logic [STICKY_W-1:0] sticky_t;
endpackage

// File: rtl/cell_gap_detector.sv
module cell_gap_detector #(
  parameter int CELL_BYTES = 53
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic byte_vld_i,
  input  logic soc_i,
  output logic short_evt_o
);
  localparam int CNT_W = $clog2(CELL_BYTES + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(CELL_BYTES);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic             primed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else if (byte_vld_i) begin
      if (soc_i) begin
        cnt_q    <= ONE;
        primed_q <= 1'b1;
      end else if (cnt_q != LIMIT) begin
        cnt_q <= cnt_q + ONE;
      end
    end
  end

  assign short_evt_o = byte_vld_i & soc_i & primed_q & (cnt_q < LIMIT);

  // R5
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    cnt_q <= LIMIT);
endmodule

// File: rtl/level_change_detector.sv
module level_change_detector (
  input  logic clk_i,
  input  logic level_i,
  output logic chg_evt_o
);
  logic prev_q;

  // captured in reset too, so a steady level never looks like a change
  always_ff @(posedge clk_i) begin
    prev_q <= level_i;
  end

  assign chg_evt_o = level_i ^ prev_q;
endmodule

// File: rtl/odd_parity_checker.sv
module odd_parity_checker #(
  parameter int DATA_W = 8
) (
  input  logic              vld_i,
  input  logic              en_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              err_o
);
  logic ones_odd;
  assign ones_odd = ^{data_i, par_i};
  assign err_o    = vld_i & en_i & ~ones_odd;
endmodule

// File: rtl/sticky_status_bank.sv
module sticky_status_bank
  import rx_stat_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  sticky_t           evt_i,
  input  logic              live_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] rd_data_o,
  output sticky_t           sticky_o,
  output logic              irq_o
);
  sticky_t sticky_q, sticky_nx;

  always_comb begin
    sticky_nx = (rd_i ? '0 : sticky_q) | evt_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sticky_q  <= '0;
      irq_o     <= 1'b0;
      rd_data_o <= '0;
    end else begin
      sticky_q <= sticky_nx;
      irq_o    <= |sticky_nx;
      if (rd_i) rd_data_o <= {1'b0, live_i, sticky_q};
    end
  end

  assign sticky_o = sticky_q;

  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_i |=> ((sticky_q & $past(sticky_q)) == $past(sticky_q)));
  // R4
  clear_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (rd_i && evt_i == '0) |=> (sticky_q == '0));
  // R9
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(irq_o) |-> $past(evt_i != '0));
  // R2
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rd_i) |-> $stable(rd_data_o));
endmodule

// File: rtl/rx_status_irq_reg.sv
module rx_status_irq_reg
  import rx_stat_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int TX_W       = 8
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              hec_err_i,
  input  logic              sym_err_i,
  input  logic              fifo_ovf_i,
  input  logic              sig_good_i,
  input  logic              rx_byte_vld_i,
  input  logic              rx_soc_i,
  input  logic              tx_byte_vld_i,
  input  logic [TX_W-1:0]   tx_data_i,
  input  logic              tx_par_i,
  input  logic              tx_par_chk_en_i,
  input  logic              rd_i,
  output logic [STAT_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic    short_evt, chg_evt, par_evt;
  sticky_t evt, sticky;

  cell_gap_detector #(.CELL_BYTES(CELL_BYTES)) gap_i (
    .clk_i(clk_i), .rst_i(rst_i), .byte_vld_i(rx_byte_vld_i),
    .soc_i(rx_soc_i), .short_evt_o(short_evt));

  level_change_detector chg_i (
    .clk_i(clk_i), .level_i(sig_good_i), .chg_evt_o(chg_evt));

  odd_parity_checker #(.DATA_W(TX_W)) par_i (
    .vld_i(tx_byte_vld_i), .en_i(tx_par_chk_en_i), .data_i(tx_data_i),
    .par_i(tx_par_i), .err_o(par_evt));

  always_comb begin
    evt          = '0;
    evt[B_OVF]   = fifo_ovf_i;
    evt[B_SYM]   = sym_err_i;
    evt[B_CHG]   = chg_evt;
    evt[B_PAR]   = par_evt;
    evt[B_SHORT] = short_evt;
    evt[B_HEC]   = hec_err_i;
  end

  sticky_status_bank bank_i (
    .clk_i(clk_i), .rst_i(rst_i), .evt_i(evt), .live_i(sig_good_i),
    .rd_i(rd_i), .rd_data_o(rd_data_o), .sticky_o(sticky), .irq_o(irq_o));

  // R8
  par_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sticky[B_PAR]) |-> $past(tx_par_chk_en_i && tx_byte_vld_i));
  // R6
  first_soc_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sticky[B_SHORT]) |-> $past(rx_soc_i && rx_byte_vld_i));
endmodule

// File: tb/rx_status_irq_reg_tb_top.sv
module rx_status_irq_reg_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hec = 0, sym = 0, ovf = 0, sig = 1;
  logic rxv = 0, soc = 0, txv = 0, txp = 0, pen = 0, rd = 0;
  logic [7:0] txd = '0;
  logic [7:0] rdat;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  rx_status_irq_reg dut_i (
    .clk_i(clk), .rst_i(rst), .hec_err_i(hec), .sym_err_i(sym),
    .fifo_ovf_i(ovf), .sig_good_i(sig), .rx_byte_vld_i(rxv), .rx_soc_i(soc),
    .tx_byte_vld_i(txv), .tx_data_i(txd), .tx_par_i(txp),
    .tx_par_chk_en_i(pen), .rd_i(rd), .rd_data_o(rdat), .irq_o(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_read(output logic [7:0] v);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    v = rdat;
  endtask

  task automatic send_byte(input logic s);
    rxv = 1'b1; soc = s;
    @(negedge clk);
    rxv = 1'b0; soc = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rd_data in reset", rdat, 8'h00);
    chk("R1 irq in reset", {7'b0, irq}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 rd_data after reset", rdat, 8'h00);
    chk("R1 irq after reset", {7'b0, irq}, 8'h00);
  endtask

  function automatic logic [7:0] live(input logic [7:0] s);
    return {1'b0, sig, s[5:0]};
  endfunction

  initial begin
    logic [7:0] v;
    @(negedge clk);
    do_reset();
    do_read(v);
    chk("R1 R7 empty word, steady level", v, 8'h40);

    // R2 R3 R9: pulse inputs onto their positions
    for (int m = 0; m < 8; m++) begin
      hec = m[2]; sym = m[1]; ovf = m[0];
      @(negedge clk);
      hec = 0; sym = 0; ovf = 0;
      chk("R9 irq after pulse", {7'b0, irq}, {7'b0, m != 0});
      do_read(v);
      chk("R2 R3 pulse bit map", v, live({2'b0, m[2], 3'b0, m[1], m[0]}));
      chk("R9 irq after clearing read", {7'b0, irq}, 8'h00);
    end

    // R4: event collides with a read
    hec = 1'b1; rd = 1'b1;
    @(negedge clk);
    hec = 1'b0; rd = 1'b0;
    chk("R4 collision not in this read", rdat, live(8'h00));
    chk("R9 irq after collision", {7'b0, irq}, 8'h01);
    repeat (4) @(negedge clk);
    do_read(v);
    chk("R4 collision kept for next read", v, live(8'h20));
    do_read(v);
    chk("R4 cleared after read", v, live(8'h00));

    // R7 R10: both directions of the level
    sig = 1'b0;
    @(negedge clk);
    do_read(v);
    chk("R7 R10 good to bad", v, 8'h04);
    do_read(v);
    chk("R10 bad live, no flag", v, 8'h00);
    sig = 1'b1;
    @(negedge clk);
    do_read(v);
    chk("R7 R10 bad to good", v, 8'h44);
    sig = 1'b0;
    @(negedge clk);
    sig = 1'b1;
    @(negedge clk);
    do_read(v);
    chk("R7 double toggle", v, 8'h44);

    // R8: every byte, parity bit and enable
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++)
        for (int d = 0; d < 256; d++) begin
          logic [7:0] exp;
          logic [7:0] db;
          db = d[7:0];
          txv = 1'b1; txd = db; txp = p[0]; pen = e[0];
          @(negedge clk);
          txv = 1'b0; pen = 1'b0;
          exp = 8'h00;
          exp[3] = e[0] & ~(^{db, p[0]});
          do_read(v);
          chk("R8 parity sweep", v, live(exp));
        end
    pen = 1'b1; txv = 1'b0; txd = 8'h00; txp = 1'b0;
    @(negedge clk);
    pen = 1'b0;
    do_read(v);
    chk("R8 no flag without valid byte", v, live(8'h00));

    // R6: first marker after reset exempt
    do_reset();
    send_byte(1'b1);
    do_read(v);
    chk("R6 first marker not checked", v, live(8'h00));

    // R5: every length 1..60, idle gaps not counted
    for (int len = 1; len <= 60; len++) begin
      for (int k = 1; k < len; k++) begin
        send_byte(1'b0);
        if (k % 7 == 0) @(negedge clk);
      end
      send_byte(1'b1);
      do_read(v);
      chk("R5 short cell by length", v, live({3'b0, len < 53, 4'b0}));
    end
    for (int k = 1; k < 300; k++) send_byte(1'b0);
    send_byte(1'b1);
    do_read(v);
    chk("R5 saturated long cell", v, live(8'h00));
    rxv = 1'b0; soc = 1'b1;
    @(negedge clk);
    soc = 1'b0;
    do_read(v);
    chk("R5 marker without valid byte ignored", v, live(8'h00));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule